// File: doc/BRIEF.md
# Infrared Link Interrupt Unit

This block collects single-cycle event pulses from the transmit and receive paths of an infrared link controller and holds them in a status byte. Status bits stay set until software clears them. A matching enable byte selects which held events assert the interrupt line. The line stays at a steady level for as long as any enabled event is pending.

Software reaches both bytes through a byte-wide register port. The status byte sits at offset 0xC and the enable byte at offset 0xD. Status bits are cleared by writing ones. The three low bits of both bytes always read as ones. A transmit-complete pulse is recorded only when the transmit slot that just finished carried its interrupt-request flag.

Top module: `irda_irq_unit`

## Requirements
- R1: The status byte reads at offset 0xC and the enable byte at offset 0xD. Any other offset reads 0x00 and ignores writes.
- R2: A pulse on rx_done_pls, tx_underrun_pls, rx_overflow_pls or rx_gap_pls sets status bit 6, 5, 4 or 3 respectively on the next clock edge. The bit then stays set until it is cleared.
- R3: Status bit 7 (transmit done) is set by a tx_done_pls pulse only when tx_slot_irq_req is high in the same cycle. With the flag low the pulse is dropped.
- R4: Writing the status offset clears every status bit in 7..3 whose write-data bit is 1. Bits written with 0 keep their value.
- R5: Writing the enable offset loads write-data bits 7..3 into the enable bits. A 1 enables that source and a 0 disables it.
- R6: Bits 2..0 of both the status and the enable byte always read as 1, whatever was written.
- R7: irq is high exactly when some bit in 7..3 is set in both the status and the enable byte. It follows register changes with no added delay.
- R8: When an event pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R9: After reset all status and enable bits are 0, both bytes read 0x07, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tx_done_pls | input | 1 | A transmit slot has finished |
| tx_slot_irq_req | input | 1 | The finished slot asked for an interrupt |
| rx_done_pls | input | 1 | A receive has completed |
| tx_underrun_pls | input | 1 | The transmit FIFO ran dry |
| rx_overflow_pls | input | 1 | The receive FIFO overflowed |
| rx_gap_pls | input | 1 | A serial gap was received |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can reach the same status bit in one cycle: a hardware event that sets it and a software write that clears it. The bench first fills the status byte. It then applies every combination of the five event pulses, with the transmit request flag both high and low, in the same cycle as every possible clear mask. Each resulting status byte is compared with the held value minus the cleared bits, plus the surviving events. The interrupt line is judged against an enable pattern that changes with each combination.

// File: rtl/irda_irq_unit.sv
module irda_irq_unit #(
  parameter int ADDR_W   = 5,
  parameter int STAT_OFS = 12,
  parameter int ENA_OFS  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tx_done_pls,
  input  logic              tx_slot_irq_req,
  input  logic              rx_done_pls,
  input  logic              tx_underrun_pls,
  input  logic              rx_overflow_pls,
  input  logic              rx_gap_pls,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] ENA_A  = ADDR_W'(ENA_OFS);

  logic [4:0] st_q, en_q, ev, clr;
  logic       sel_st, sel_en;

  assign sel_st = reg_addr == STAT_A;
  assign sel_en = reg_addr == ENA_A;
  assign ev  = {tx_done_pls & tx_slot_irq_req, rx_done_pls,
                tx_underrun_pls, rx_overflow_pls, rx_gap_pls};
  assign clr = (reg_wr && sel_st) ? reg_wdata[7:3] : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= (st_q & ~clr) | ev;
      if (reg_wr && sel_en) en_q <= reg_wdata[7:3];
    end
  end

  assign irq = |(st_q & en_q);
  assign reg_rdata = sel_st ? {st_q, 3'b111} :
                     sel_en ? {en_q, 3'b111} : 8'h00;
endmodule

module irda_irq_unit_chk #(
  parameter int ADDR_W   = 5,
  parameter int STAT_OFS = 12,
  parameter int ENA_OFS  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              tx_done_pls,
  input logic              tx_slot_irq_req,
  input logic              rx_done_pls,
  input logic              tx_underrun_pls,
  input logic              rx_overflow_pls,
  input logic              rx_gap_pls,
  input logic              irq,
  input logic [4:0]        st_q,
  input logic [4:0]        en_q
);
  logic any_ev;
  assign any_ev = tx_done_pls | rx_done_pls | tx_underrun_pls | rx_overflow_pls | rx_gap_pls;

  // R2 R8
  rx_done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_pls |=> st_q[3]);
  // R3
  tx_done_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_pls && tx_slot_irq_req) |=> st_q[4]);
  // R3
  tx_done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_slot_irq_req && !st_q[4]) |=> !st_q[4]);
  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(STAT_OFS) && !any_ev) |=> ((st_q & $past(reg_wdata[7:3])) == 5'd0));
  // R5
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(ENA_OFS)) |=> en_q == $past(reg_wdata[7:3]));
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 5'd0) |-> !irq);
  // R6
  always_comb
    if (rst_n && (reg_addr == ADDR_W'(STAT_OFS) || reg_addr == ADDR_W'(ENA_OFS)))
      fixed_ones_chk: assert (reg_rdata[2:0] == 3'b111);
endmodule

bind irda_irq_unit irda_irq_unit_chk #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .ENA_OFS(ENA_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .tx_done_pls(tx_done_pls), .tx_slot_irq_req(tx_slot_irq_req),
  .rx_done_pls(rx_done_pls), .tx_underrun_pls(tx_underrun_pls), .rx_overflow_pls(rx_overflow_pls),
  .rx_gap_pls(rx_gap_pls), .irq(irq), .st_q(st_q), .en_q(en_q));

// File: tb/sim_irda_irq_unit.sv
module sim_irda_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_ST = 5'd12, A_EN = 5'd13;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [4:0] reg_addr = A_ST;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic tx_done_pls = 0, tx_slot_irq_req = 0, rx_done_pls = 0;
  logic tx_underrun_pls = 0, rx_overflow_pls = 0, rx_gap_pls = 0, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irda_irq_unit u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_done_pls(tx_done_pls),
    .tx_slot_irq_req(tx_slot_irq_req), .rx_done_pls(rx_done_pls),
    .tx_underrun_pls(tx_underrun_pls), .rx_overflow_pls(rx_overflow_pls),
    .rx_gap_pls(rx_gap_pls), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(logic wr, logic [4:0] a, logic [7:0] d, logic [4:0] ev, logic req);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tx_slot_irq_req = req;
    {tx_done_pls, rx_done_pls, tx_underrun_pls, rx_overflow_pls, rx_gap_pls} = ev;
    @(negedge clk);
    reg_wr = 0; tx_slot_irq_req = 0;
    {tx_done_pls, rx_done_pls, tx_underrun_pls, rx_overflow_pls, rx_gap_pls} = 0;
  endtask

  task automatic rd(logic [4:0] a);
    reg_addr = a; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(A_ST); chk("R9", reg_rdata, 8'h07);
    rd(A_EN); chk("R9", reg_rdata, 8'h07);
    chk("R9", {7'd0, irq}, 8'h00);
    rd(5'd14); chk("R1", reg_rdata, 8'h00);
    drive(1, 5'd14, 8'hFF, 5'd0, 0);
    rd(A_EN); chk("R1", reg_rdata, 8'h07);
    for (int e = 0; e < 32; e++) begin
      drive(1, A_EN, {e[4:0], 3'b000}, 5'd0, 0);
      rd(A_EN); chk("R5 R6", reg_rdata, {e[4:0], 3'b111});
    end
    // TxDone without request is dropped (R3)
    drive(1, A_ST, 8'hFF, 5'd0, 0);
    drive(0, A_ST, 8'h00, 5'b10000, 0);
    rd(A_ST); chk("R3", reg_rdata, 8'h07);
    // Main sweep: every event set x request flag x clear mask (R2 R3 R4 R7 R8)
    for (int ev = 0; ev < 32; ev++)
      for (int rq = 0; rq < 2; rq++)
        for (int cl = 0; cl < 32; cl++) begin
          logic [4:0] en, eff, exp;
          en  = ev[4:0] ^ cl[4:0] ^ 5'(rq);
          eff = ev[4:0] & {rq[0], 4'b1111};
          exp = (5'h1F & ~cl[4:0]) | eff;
          drive(1, A_EN, {en, 3'b000}, 5'h1F, 1);
          rd(A_ST); chk("R2", reg_rdata, 8'hFF);
          drive(1, A_ST, {cl[4:0], 3'b000}, ev[4:0], rq[0]);
          rd(A_ST); chk("R4 R8 R3", reg_rdata, {exp, 3'b111});
          chk("R7", {7'd0, irq}, {7'd0, |(exp & en)});
          drive(0, A_ST, 8'hFF, 5'd0, 0);
          rd(A_ST); chk("R2", reg_rdata, {exp, 3'b111});
        end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule